// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat burst into a synchronous burst memory. A burst opens when either of two active-low address strobes is sampled low at a rising clock edge. On that edge the block captures the external word address and the order-select input. After that, each edge that sees the active-low advance input low, with both strobes high, moves the burst on by one beat. An edge with advance high and both strobes high suspends the burst and holds the address.

Only the low-order word-address bits take part in the burst. Two orders are available. In interleaved order each beat's low bits are the start bits XORed with the beat number. In linear order they are the start bits plus the beat number, wrapping within the aligned group. The upper address bits are copied from the load and never change until the next load. The current address and a beat index come straight from registers, so they settle one edge after the inputs that caused them.

Top module: `burst_seq_gen`

## Requirements
- R1: A synchronous active-high `rst` sampled high forces `addr_out` to 0 and `beat` to 0 at that edge, and selects linear order until the next load.
- R2: When `ilv_mode` was 1 at the load edge, the low two bits of `addr_out` equal the captured start bits XOR `beat` (start 01 gives 01,00,11,10; start 10 gives 10,11,00,01; start 11 gives 11,10,01,00).
- R3: When `ilv_mode` was 0 at the load edge, the low two bits of `addr_out` equal the captured start bits plus `beat`, modulo 4 (start 01 gives 01,10,11,00; start 11 gives 11,00,01,10).
- R4: An edge with `cpu_strobe_n` low, `ctl_strobe_n` low, or both low loads the burst: on the next cycle `addr_out` equals the `addr_in` sampled at that edge and `beat` is 0.
- R5: An edge with both strobes high and `adv_n` low increments `beat` by one, modulo 4.
- R6: An edge with both strobes high and `adv_n` high leaves `addr_out` and `beat` unchanged.
- R7: Bits above the low two of `addr_out` change only on a load. An advance from beat 3 returns to beat 0 and to the start address, with no carry into the upper bits.
- R8: `ilv_mode` is sampled only at a load edge. Changing it during a burst has no effect on the sequence.
- R9: A strobe takes priority over advance: an edge with a strobe low and `adv_n` low loads and does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low; starts a burst |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low; starts a burst |
| adv_n | input | 1 | Advance enable, active low; steps the burst when no strobe is low |
| ilv_mode | input | 1 | Order select captured at load: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W (16) | External start word address |
| addr_out | output | ADDR_W (16) | Current word address |
| beat | output | log2(BURST_LEN) (2) | Index of the current beat within the burst |

## Verification
The captured start bits, the beat count and the latched order are held in separate registers and combined only at the output. A wrong value in any of them shows on `addr_out` or `beat` in the first cycle after the edge that wrote it. A wrong start or order shows as a low-bit pattern that breaks the start-XOR-beat or start-plus-beat relation. A wrong count shows as a beat that is not the previous beat plus one. A stray carry shows in the upper bits on the first advance past beat 3. The bench therefore compares both outputs every cycle, so each fault is caught within one cycle of the edge where it arises.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

    // Action chosen for one clock edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } act_e;

    // Beat order latched at load time
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } ord_e;

endpackage

// File: rtl/bsg_cmd_decode.sv
module bsg_cmd_decode
    import bsg_pkg::*;
(
    input  logic cpu_strobe_n,
    input  logic ctl_strobe_n,
    input  logic adv_n,
    output act_e act
);

    logic any_strobe;

    always_comb begin
        any_strobe = !cpu_strobe_n || !ctl_strobe_n;
        if (any_strobe) begin
            act = ACT_LOAD;        // a strobe outranks advance
        end else if (!adv_n) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;        // suspended burst
        end
    end

endmodule

// File: rtl/bsg_order.sv
module bsg_order
    import bsg_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start,
    input  logic [LOW_W-1:0] cnt,
    input  ord_e             mode,
    output logic [LOW_W-1:0] low
);

    logic [LOW_W-1:0] ilv_low;
    logic [LOW_W-1:0] lin_low;

    // Interleaved order: each bit of the start toggled by the beat count
    genvar b;
    generate
        for (b = 0; b < LOW_W; b++) begin : g_ilv_bit
            assign ilv_low[b] = start[b] ^ cnt[b];
        end
    endgenerate

    // Linear order: modular add, the carry out of the top bit is dropped
    always_comb begin
        lin_low = start + cnt;
    end

    always_comb begin
        low = (mode == ORD_INTERLEAVE) ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import bsg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cpu_strobe_n,
    input  logic                          ctl_strobe_n,
    input  logic                          adv_n,
    input  logic                          ilv_mode,
    input  logic [ADDR_W-1:0]             addr_in,
    output logic [ADDR_W-1:0]             addr_out,
    output logic [$clog2(BURST_LEN)-1:0]  beat
);

    localparam int LOW_W = $clog2(BURST_LEN);
    localparam int UP_W  = ADDR_W - LOW_W;

    typedef struct packed {
        logic [UP_W-1:0]  upper;
        logic [LOW_W-1:0] start;
        logic [LOW_W-1:0] cnt;
        ord_e             mode;
    } state_t;

    state_t st_d;
    state_t st_q;
    act_e   act;
    logic [LOW_W-1:0] low_cur;

    bsg_cmd_decode u_dec (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .adv_n        (adv_n),
        .act          (act)
    );

    bsg_order #(.LOW_W(LOW_W)) u_ord (
        .start (st_q.start),
        .cnt   (st_q.cnt),
        .mode  (st_q.mode),
        .low   (low_cur)
    );

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_LOAD: begin
                st_d.upper = addr_in[ADDR_W-1:LOW_W];
                st_d.start = addr_in[LOW_W-1:0];
                st_d.cnt   = '0;
                st_d.mode  = ilv_mode ? ORD_INTERLEAVE : ORD_LINEAR;
            end
            ACT_STEP: begin
                st_d.cnt = st_q.cnt + 1'b1;   // wraps inside the group
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out = {st_q.upper, low_cur};
    assign beat     = st_q.cnt;

endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cpu_strobe_n,
    input logic                          ctl_strobe_n,
    input logic                          adv_n,
    input logic                          ilv_mode,
    input logic [ADDR_W-1:0]             addr_in,
    input logic [ADDR_W-1:0]             addr_out,
    input logic [$clog2(BURST_LEN)-1:0]  beat
);

    localparam int LOW_W = $clog2(BURST_LEN);

    logic             ck_valid;
    logic             ck_ilv;
    logic [LOW_W-1:0] ck_start;
    logic             strobe_any;
    logic [LOW_W-1:0] lin_exp;
    logic [LOW_W-1:0] ilv_exp;
    logic [LOW_W-1:0] beat_inc;

    assign strobe_any = !cpu_strobe_n || !ctl_strobe_n;
    assign lin_exp    = ck_start + beat;
    assign ilv_exp    = ck_start ^ beat;
    assign beat_inc   = beat + 1'b1;

    // Start bits and order seen at the port on each load
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_valid <= 1'b0;
            ck_ilv   <= 1'b0;
            ck_start <= '0;
        end else if (strobe_any) begin
            ck_valid <= 1'b1;
            ck_ilv   <= ilv_mode;
            ck_start <= addr_in[LOW_W-1:0];
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && beat == '0));

    a_r2_ilv_order: assert property (@(posedge clk) disable iff (rst)
        (ck_valid && ck_ilv) |-> (addr_out[LOW_W-1:0] == ilv_exp));

    a_r3_lin_order: assert property (@(posedge clk) disable iff (rst)
        (ck_valid && !ck_ilv) |-> (addr_out[LOW_W-1:0] == lin_exp));

    // R9: a strobe wins over a simultaneous advance
    a_r4_load_captures: assert property (@(posedge clk) disable iff (rst)
        strobe_any |=> (addr_out == $past(addr_in) && beat == '0));

    a_r5_step_counts: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && !adv_n) |=> (beat == $past(beat_inc)));

    a_r6_hold_still: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && adv_n) |=> ($stable(addr_out) && $stable(beat)));

    a_r7_upper_stable: assert property (@(posedge clk) disable iff (rst)
        !strobe_any |=> $stable(addr_out[ADDR_W-1:LOW_W]));

endmodule

bind burst_seq_gen bsg_checker #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .adv_n        (adv_n),
    .ilv_mode     (ilv_mode),
    .addr_in      (addr_in),
    .addr_out     (addr_out),
    .beat         (beat)
);

// File: tb/sim_burst_seq_gen.sv
`timescale 1ns/1ps
module sim_burst_seq_gen;

    localparam int AW = 16;
    localparam int BL = 4;
    localparam int LW = $clog2(BL);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_strobe_n = 1'b1;
    logic          ctl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          ilv_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [LW-1:0] beat;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Scoreboard queues, one entry per clock edge
    logic [AW-1:0] q_addr[$];
    logic [LW-1:0] q_beat[$];
    string         q_tag[$];

    // Reference state built from the requirements
    logic [AW-LW-1:0] m_up    = '0;
    logic [LW-1:0]    m_start = '0;
    logic [LW-1:0]    m_cnt   = '0;
    logic             m_ilv   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    burst_seq_gen #(.ADDR_W(AW), .BURST_LEN(BL)) u0 (
        .clk          (clk),
        .rst          (rst),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .adv_n        (adv_n),
        .ilv_mode     (ilv_mode),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .beat         (beat)
    );

    task automatic cyc(input logic r, input logic c1, input logic c2,
                       input logic a, input logic m,
                       input logic [AW-1:0] ad, input string tag);
        logic [LW-1:0] low;
        @(negedge clk);
        rst = r; cpu_strobe_n = c1; ctl_strobe_n = c2;
        adv_n = a; ilv_mode = m; addr_in = ad;
        if (r) begin
            m_up = '0; m_start = '0; m_cnt = '0; m_ilv = 1'b0;
        end else if (!c1 || !c2) begin
            m_up = ad[AW-1:LW]; m_start = ad[LW-1:0]; m_cnt = '0; m_ilv = m;
        end else if (!a) begin
            m_cnt = m_cnt + 1'b1;
        end
        low = m_ilv ? (m_start ^ m_cnt) : (m_start + m_cnt);
        q_addr.push_back({m_up, low});
        q_beat.push_back(m_cnt);
        q_tag.push_back(tag);
    endtask

    task automatic adv(input int n, input logic m, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, m, 16'h0000, tag);
    endtask

    task automatic hold(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'hDEAD, tag);
    endtask

    // Monitor: compares the outputs a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q_addr.size() > 0) begin
                logic [AW-1:0] ea;
                logic [LW-1:0] eb;
                string         t;
                ea = q_addr.pop_front();
                eb = q_beat.pop_front();
                t  = q_tag.pop_front();
                n_run++;
                if (addr_out !== ea || beat !== eb) begin
                    n_fail++;
                    $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
                             t, addr_out, beat, ea, eb);
                end
            end
        end
    end

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, "R1");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF, "R1");
        // R4 via processor strobe, R3 linear from start 01, R7 wrap
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA5C1, "R4");
        adv(3, 1'b0, "R3");
        adv(1, 1'b0, "R7");
        // R6 suspend, then resume with R5
        hold(2, "R6");
        adv(2, 1'b0, "R5");
        hold(1, "R6");
        // R4 via controller strobe, R2 interleaved from start 10
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1232, "R4");
        adv(3, 1'b1, "R2");
        // R2 from start 11, R8 mode changes mid-burst are ignored
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h7FFF, "R4");
        adv(3, 1'b0, "R8");
        adv(6, 1'b1, "R7");
        // R3 from start 11 with both strobes low and advance low (R9)
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0003, "R9");
        adv(3, 1'b1, "R3");
        // R9: strobe during an active burst with advance low reloads
        adv(1, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFD, "R9");
        adv(3, 1'b0, "R2");
        adv(1, 1'b0, "R7");
        // R1: reset mid-burst, even with a strobe low
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h4444, "R1");
        hold(1, "R1");
        adv(2, 1'b1, "R1");
        // drain
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule